// File: doc/BRIEF.md
# I2C Master Bit Engine

This block drives the two wires of an I2C bus as the single master, one bus primitive per command. A sequencer above it issues commands in order: bus recovery, START, STOP, write a byte, or read a byte and answer with a chosen acknowledge level. The engine answers each command with a one-cycle completion pulse. With that pulse it returns the received byte, or the acknowledge bit that the slave gave after a write. Both wires are open-drain. The engine only ever asserts drive-low enables, and a released wire is pulled high outside the block.

All bus timing is counted in delay units. A unit lasts `cmd_div + 1` clock cycles, and the divider value is captured when the command is accepted. A byte takes nine SCL periods of four units each: two low and two high. A final low unit then leaves SCL low for the next byte. The SDA input passes through a two-flop synchroniser before it is sampled.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset, `scl_oe` and `sda_oe` are 0 (both wires released), `cmd_ready` is 1, `done` is 0, `rx_byte` is 0x00 and `ack_n` is 0.
- R2: A command is taken in a cycle where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is then 0 until the completion cycle. In that cycle `done` is 1 for exactly one cycle and `cmd_ready` is 1 again.
- R3: Each delay unit lasts `cmd_div + 1` cycles, using the `cmd_div` value present at acceptance. Later changes to `cmd_div` have no effect on a running command. Unit 0 starts on the first cycle after acceptance, and `done` rises in the cycle after the last unit ends.
- R4: START (op code 1) takes 3 units. Unit 0 releases SDA and leaves SCL as it was. Unit 1 releases SCL. Unit 2 pulls SDA low while SCL stays released.
- R5: STOP (op code 2) takes 4 units: SCL low, then SDA low, then SCL released, then SDA released. It ends with both wires released.
- R6: Write (op code 3) sends `cmd_wdata` MSB first. Bit k uses units 4k..4k+3: SCL goes low in unit 4k, SDA takes the bit in unit 4k+1, and SCL is released in units 4k+2 and 4k+3.
- R7: In a write, SDA is released in unit 33 for the ninth clock. The line value is sampled at the end of unit 35 while SCL is high, and it is returned on `ack_n` (0 means acknowledged).
- R8: Read (op code 4) releases SDA in unit 4k+1 for bits k = 0..7. It samples SDA at the end of unit 4k+2, one unit after SCL rises, and assembles `rx_byte` MSB first. Commands other than read leave `rx_byte` unchanged.
- R9: In a read, the engine drives SDA to the level `cmd_ack_n` in unit 33, on the ninth clock, and returns that level on `ack_n`.
- R10: Recovery (op code 0) takes 40 units. SDA is released from unit 1, and units 0..35 give nine SCL pulses, each two units low and two units high. Units 36..39 form a STOP sequence.
- R11: During write and read, SDA changes only while SCL has been held low for at least one cycle.
- R12: Op codes 5, 6 and 7 take one unit, leave both wires unchanged, and return `ack_n` = 0. START, STOP and recovery also return `ack_n` = 0.
- R13: Write and read end with one extra unit (unit 36) in which SCL is pulled low and SDA is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command may be taken |
| cmd_op | input | 3 | 0 recover, 1 START, 2 STOP, 3 write, 4 read |
| cmd_wdata | input | 8 | Byte to write |
| cmd_ack_n | input | 1 | Acknowledge level to send after a read byte |
| cmd_div | input | DIV_W | Delay unit length minus one, in cycles |
| sda_i | input | 1 | SDA wire level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| done | output | 1 | One-cycle completion pulse |
| rx_byte | output | 8 | Byte received by the last read |
| ack_n | output | 1 | Acknowledge result of the completed command |

## Verification
The bench keeps `DIV_W` at its default of 16 and changes `cmd_div` from command to command. A value of 0 gives single-cycle units, where the unit boundaries in the START sequence are visible at every edge. Values of 1 to 3 give multi-cycle units, which expose off-by-one errors in the reload and in the sample point. One write changes `cmd_div` while the command is running, which shows whether the value captured at acceptance is the one in use. A bench-side slave drives the wired-AND SDA line with both acknowledge outcomes and with two distinct read patterns.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

  localparam int UNIT_W = 6;

  localparam logic [2:0] OP_RECOVER = 3'd0;
  localparam logic [2:0] OP_START   = 3'd1;
  localparam logic [2:0] OP_STOP    = 3'd2;
  localparam logic [2:0] OP_WRITE   = 3'd3;
  localparam logic [2:0] OP_READ    = 3'd4;

  // per-unit wire action: *_set chooses whether the wire is updated
  typedef struct packed {
    logic scl_set;
    logic scl_low;
    logic sda_set;
    logic sda_low;
  } drive_t;

  function automatic drive_t mk_drive(logic ss, logic sl, logic ds, logic dl);
    drive_t d;
    d.scl_set = ss;
    d.scl_low = sl;
    d.sda_set = ds;
    d.sda_low = dl;
    return d;
  endfunction

  function automatic drive_t stop_drive(logic [1:0] s);
    case (s)
      2'd0:    return mk_drive(1'b1, 1'b1, 1'b0, 1'b0);
      2'd1:    return mk_drive(1'b0, 1'b0, 1'b1, 1'b1);
      2'd2:    return mk_drive(1'b1, 1'b0, 1'b0, 1'b0);
      default: return mk_drive(1'b0, 1'b0, 1'b1, 1'b0);
    endcase
  endfunction

  function automatic logic [UNIT_W-1:0] unit_count(logic [2:0] op);
    case (op)
      OP_RECOVER: return UNIT_W'(40);
      OP_START:   return UNIT_W'(3);
      OP_STOP:    return UNIT_W'(4);
      OP_WRITE,
      OP_READ:    return UNIT_W'(37);
      default:    return UNIT_W'(1);
    endcase
  endfunction

  function automatic logic is_byte_op(logic [2:0] op);
    return (op == OP_WRITE) || (op == OP_READ);
  endfunction

  function automatic drive_t unit_drive(logic [2:0] op, logic [UNIT_W-1:0] u,
                                        logic [7:0] wdata, logic ackn);
    logic [1:0] ph;
    logic [3:0] bitn;
    logic       lvl;
    ph   = u[1:0];
    bitn = u[5:2];
    case (op)
      OP_RECOVER: begin
        if (u >= UNIT_W'(36))
          return stop_drive(2'(u - UNIT_W'(36)));
        return mk_drive(1'b1, ~ph[1], (u != '0), 1'b0);
      end
      OP_START: begin
        if (u == UNIT_W'(0)) return mk_drive(1'b0, 1'b0, 1'b1, 1'b0);
        if (u == UNIT_W'(1)) return mk_drive(1'b1, 1'b0, 1'b0, 1'b0);
        return mk_drive(1'b0, 1'b0, 1'b1, 1'b1);
      end
      OP_STOP:
        return stop_drive(u[1:0]);
      OP_WRITE, OP_READ: begin
        if (u == UNIT_W'(36)) return mk_drive(1'b1, 1'b1, 1'b0, 1'b0);
        case (ph)
          2'd0: return mk_drive(1'b1, 1'b1, 1'b0, 1'b0);
          2'd1: begin
            if (bitn < 4'd8)
              lvl = (op == OP_WRITE) ? wdata[3'd7 - bitn[2:0]] : 1'b1;
            else
              lvl = (op == OP_WRITE) ? 1'b1 : ackn;
            return mk_drive(1'b0, 1'b0, 1'b1, ~lvl);
          end
          2'd2:    return mk_drive(1'b1, 1'b0, 1'b0, 1'b0);
          default: return mk_drive(1'b0, 1'b0, 1'b0, 1'b0);
        endcase
      end
      default:
        return mk_drive(1'b0, 1'b0, 1'b0, 1'b0);
    endcase
  endfunction

  // SDA is captured at the end of these units
  function automatic logic unit_samples(logic [2:0] op, logic [UNIT_W-1:0] u);
    if (op == OP_WRITE) return (u == UNIT_W'(35));
    if (op == OP_READ)  return (u < UNIT_W'(32)) && (u[1:0] == 2'd2);
    return 1'b0;
  endfunction

endpackage

// File: rtl/i2cb_unit_timer.sv
module i2cb_unit_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic             run,
  output logic             tick,
  output logic [DIV_W-1:0] div_q
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= '0;
    end else if (load) begin
      cnt_q <= div_in;
      div_q <= div_in;
    end else if (run) begin
      cnt_q <= (cnt_q == '0) ? div_q : cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/i2cb_sync.sv
module i2cb_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] st;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[i] <= RESET_VAL;
      else        st[i] <= (i == 0) ? d : st[(i == 0) ? 0 : i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/i2cb_shifter.sv
module i2cb_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (en)  q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2cb_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int SYNC_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [7:0]       cmd_wdata,
  input  logic             cmd_ack_n,
  input  logic [DIV_W-1:0] cmd_div,
  input  logic             sda_i,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             done,
  output logic [7:0]       rx_byte,
  output logic             ack_n
);
  localparam int BYTE_W = 8;

  logic              busy_q;
  logic [2:0]        op_q;
  logic [7:0]        wdata_q;
  logic              ackn_q;
  logic [UNIT_W-1:0] unit_q;
  logic [DIV_W-1:0]  div_q;
  logic              tick;
  logic              sda_s;
  logic [BYTE_W-1:0] shift_q;

  // named events for the checker
  logic   accept;
  logic   last_unit;
  logic   finish;
  logic   smp_en;
  drive_t drv;

  assign cmd_ready = !busy_q;
  assign accept    = cmd_valid && cmd_ready;
  assign last_unit = (unit_q == unit_count(op_q) - UNIT_W'(1));
  assign finish    = tick && last_unit;
  assign smp_en    = tick && unit_samples(op_q, unit_q);
  assign drv       = accept ? unit_drive(cmd_op, '0, cmd_wdata, cmd_ack_n)
                            : unit_drive(op_q, unit_q + UNIT_W'(1), wdata_q, ackn_q);

  i2cb_unit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .div_in (cmd_div),
    .run    (busy_q),
    .tick   (tick),
    .div_q  (div_q)
  );

  i2cb_sync #(.STAGES(SYNC_LEN), .RESET_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sda_i),
    .q     (sda_s)
  );

  i2cb_shifter #(.W(BYTE_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .en    (smp_en),
    .din   (sda_s),
    .q     (shift_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      op_q    <= '0;
      wdata_q <= '0;
      ackn_q  <= 1'b0;
      unit_q  <= '0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
      done    <= 1'b0;
      rx_byte <= '0;
      ack_n   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        op_q    <= cmd_op;
        wdata_q <= cmd_wdata;
        ackn_q  <= cmd_ack_n;
        unit_q  <= '0;
        if (drv.scl_set) scl_oe <= drv.scl_low;
        if (drv.sda_set) sda_oe <= drv.sda_low;
      end else if (finish) begin
        busy_q <= 1'b0;
        done   <= 1'b1;
        if (op_q == OP_READ) begin
          rx_byte <= shift_q;
          ack_n   <= ackn_q;
        end else if (op_q == OP_WRITE) begin
          ack_n   <= shift_q[0];
        end else begin
          ack_n   <= 1'b0;
        end
      end else if (tick) begin
        unit_q <= unit_q + UNIT_W'(1);
        if (drv.scl_set) scl_oe <= drv.scl_low;
        if (drv.sda_set) sda_oe <= drv.sda_low;
      end
    end
  end
endmodule

// File: rtl/i2cb_checker.sv
module i2cb_checker #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_ready,
  input logic             accept,
  input logic             done,
  input logic             busy,
  input logic [DIV_W-1:0] div_q,
  input logic [2:0]       op,
  input logic [5:0]       unit,
  input logic             scl_oe,
  input logic             sda_oe,
  input logic             smp_en
);
  assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cmd_ready);

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);

  assert_div_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(div_q));

  assert_sda_moves_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (op == 3'd3 || op == 3'd4) && (sda_oe != $past(sda_oe)))
      |-> (scl_oe && $past(scl_oe)));

  assert_recover_sda_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op == 3'd0 && unit >= 6'd1 && unit <= 6'd36) |-> !sda_oe);

  assert_stop_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op == 3'd2) |-> (!scl_oe && !sda_oe));

  assert_sample_scl_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en |-> !scl_oe);
endmodule

bind i2c_bit_engine i2cb_checker #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .accept    (accept),
  .done      (done),
  .busy      (busy_q),
  .div_q     (div_q),
  .op        (op_q),
  .unit      (unit_q),
  .scl_oe    (scl_oe),
  .sda_oe    (sda_oe),
  .smp_en    (smp_en)
);

// File: tb/tb_i2c_bit_engine.sv
module tb_i2c_bit_engine;
  localparam int DIV_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [2:0]       cmd_op = '0;
  logic [7:0]       cmd_wdata = '0;
  logic             cmd_ack_n = 1'b0;
  logic [DIV_W-1:0] cmd_div = '0;
  logic             sda_i;
  logic             scl_oe, sda_oe, done, ack_n;
  logic [7:0]       rx_byte;
  logic             slave_pull = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // model state: wire levels, -1 means keep
  int scl_lvl = 1, sda_lvl = 1;
  int q_scl[$], q_sda[$], q_pull[$];
  logic [7:0] exp_rx = 8'h00;

  always #4 clk = ~clk;

  assign sda_i = !(sda_oe || slave_pull);

  i2c_bit_engine #(.DIV_W(DIV_W)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .cmd_ack_n(cmd_ack_n),
    .cmd_div(cmd_div), .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .done(done), .rx_byte(rx_byte), .ack_n(ack_n)
  );

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(int s, int d, int p);
    q_scl.push_back(s);
    q_sda.push_back(d);
    q_pull.push_back(p);
  endtask

  // slave_bits: read data, or for write bit 0 = slave acknowledges
  task automatic build(int op, logic [7:0] wd, logic ackn, logic [7:0] slave_bits);
    q_scl.delete(); q_sda.delete(); q_pull.delete();
    case (op)
      0: begin
        for (int u = 0; u < 36; u++) step((u % 4 < 2) ? 0 : 1, (u == 0) ? -1 : 1, 0);
        step(0, -1, 0); step(-1, 0, 0); step(1, -1, 0); step(-1, 1, 0);
      end
      1: begin step(-1, 1, 0); step(1, -1, 0); step(-1, 0, 0); end
      2: begin step(0, -1, 0); step(-1, 0, 0); step(1, -1, 0); step(-1, 1, 0); end
      3, 4: begin
        for (int b = 0; b < 9; b++) begin
          int lvl, pull;
          if (op == 3) begin
            lvl  = (b < 8) ? int'(wd[7-b]) : 1;
            pull = (b == 8) ? int'(slave_bits[0]) : 0;
          end else begin
            lvl  = (b < 8) ? 1 : int'(ackn);
            pull = (b < 8) ? int'(!slave_bits[7-b]) : 0;
          end
          step(0, -1, pull); step(-1, lvl, pull); step(1, -1, pull); step(-1, -1, pull);
        end
        step(0, -1, 0);
      end
      default: step(-1, -1, 0);
    endcase
  endtask

  task automatic run(int op, logic [7:0] wd, logic ackn, logic [7:0] sbits,
                     int div, bit swap_div, string tag);
    int exp_ack;
    build(op, wd, ackn, sbits);
    @(negedge clk);
    check({"R2 ready before ", tag}, cmd_ready, 1);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_wdata = wd; cmd_ack_n = ackn;
    cmd_div = DIV_W'(div);
    @(posedge clk);
    for (int u = 0; u < q_scl.size(); u++) begin
      if (q_scl[u] >= 0) scl_lvl = q_scl[u];
      if (q_sda[u] >= 0) sda_lvl = q_sda[u];
      for (int j = 0; j <= div; j++) begin
        @(negedge clk);
        if (u == 0 && j == 0) begin
          cmd_valid = 1'b0;
          if (swap_div) cmd_div = DIV_W'(div + 5);
        end
        if (j == 0) slave_pull = q_pull[u][0];
        check({tag, " scl"}, scl_oe, (scl_lvl == 0) ? 1 : 0);
        check({tag, " sda"}, sda_oe, (sda_lvl == 0) ? 1 : 0);
        check({"R2 R3 busy ", tag}, cmd_ready, 0);
        check({"R3 no early done ", tag}, done, 0);
      end
    end
    @(negedge clk);
    slave_pull = 1'b0;
    check({"R2 R3 done ", tag}, done, 1);
    check({"R2 ready at done ", tag}, cmd_ready, 1);
    check({tag, " scl held"}, scl_oe, (scl_lvl == 0) ? 1 : 0);
    check({tag, " sda held"}, sda_oe, (sda_lvl == 0) ? 1 : 0);
    if (op == 4) exp_rx = sbits;
    if (op == 3)      exp_ack = sbits[0] ? 0 : 1;
    else if (op == 4) exp_ack = int'(ackn);
    else              exp_ack = 0;
    check({"R7 R9 R12 ack ", tag}, ack_n, exp_ack);
    check({"R8 R12 rx ", tag}, rx_byte, exp_rx);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 scl_oe", scl_oe, 0);
    check("R1 sda_oe", sda_oe, 0);
    check("R1 ready", cmd_ready, 1);
    check("R1 done", done, 0);
    check("R1 rx_byte", rx_byte, 0);
    check("R1 ack_n", ack_n, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(0, 8'h00, 1'b0, 8'h00, 1, 0, "R10 recover");
    run(1, 8'h00, 1'b0, 8'h00, 0, 0, "R4 R3 start div0");
    run(3, 8'hA5, 1'b0, 8'h01, 2, 0, "R6 R7 R11 R13 write ack");
    run(3, 8'h3C, 1'b0, 8'h00, 3, 1, "R3 R6 R7 R13 write nack");
    run(4, 8'h00, 1'b0, 8'h96, 2, 0, "R8 R9 R11 R13 read ack");
    run(4, 8'h00, 1'b1, 8'h5B, 1, 0, "R8 R9 R13 read nack");
    run(2, 8'h00, 1'b0, 8'h00, 2, 0, "R5 stop");
    run(6, 8'hFF, 1'b1, 8'h00, 1, 0, "R12 op6");
    run(1, 8'h00, 1'b0, 8'h00, 1, 0, "R4 start");
    run(3, 8'h81, 1'b0, 8'h01, 1, 1, "R6 R7 write");
    run(7, 8'h00, 1'b0, 8'h00, 0, 0, "R12 op7");
    run(2, 8'h00, 1'b0, 8'h00, 0, 0, "R5 stop div0");
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule